// File: doc/BRIEF.md
# Link Retry Replay Timer

This block times the acknowledgement of transmitted packets in a link-layer retry scheme. It watches three events each cycle: a transaction packet being written into the retry buffer, a valid acknowledgement (positive or negative) arriving from the far end, and whether unacknowledged packets remain held after that cycle. The timer runs while any packet is held and unacknowledged. If no acknowledgement arrives before the count reaches the timeout limit, the block raises a single-cycle replay request. The replay logic then resends every unacknowledged packet.

The timeout limit depends on the negotiated link speed and width. A 24-bit policy word, which software can read and write, holds six 4-bit fields, one for each speed/width pair. The selected field is multiplied by a parameterised scale (default 64 link clocks) to form the limit in cycles. A speed or width code that is not supported falls back to the Gen1 x1 field. After a replay request the count restarts from zero and the timer stays armed, because the packets remain held while they are replayed.

Top module: `rtt_replay_timer`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) loads the policy word 24'hA64F96, stops the timer and clears the replay request.
- R2: When `pol_we` is high at a clock edge, `pol_rdata` shows `pol_wdata` after that edge. Otherwise the policy word holds its value.
- R3: The limit is field × SCALE. `link_speed` 0 selects Gen1 and 1 selects Gen2. `link_width` 0 selects x1, 1 selects x2 and 2 selects x4. The field positions are: Gen1 x4 at bits 3:0, Gen1 x2 at 7:4, Gen1 x1 at 11:8, Gen2 x4 at 15:12, Gen2 x2 at 19:16 and Gen2 x1 at 23:20.
- R4: A `link_speed` of 2 or 3, or a `link_width` of 3, selects the Gen1 x1 field (bits 11:8).
- R5: While the timer is idle, `tlp_wr` with no `ack_rx` arms it with a count of zero. While the timer is idle and neither input is asserted, it stays idle.
- R6: `ack_rx` with `rb_pend` high restarts the count from zero, and the timer runs afterwards.
- R7: `ack_rx` with `rb_pend` low clears the count, and the timer goes idle with no replay request.
- R8: `replay_req` is a one-cycle pulse that appears exactly limit cycles after the edge that armed or restarted the count. The count then restarts from zero, so the pulses repeat every limit cycles until an acknowledgement arrives.
- R9: An `ack_rx` in the cycle where the count would expire takes precedence, and no replay request is raised.
- R10: `tlp_wr` while the timer runs does not restart the count.
- R11: A selected field of zero raises a replay request on every cycle while the timer runs.
- R12: If the limit drops to or below the current count, the replay request appears on the first edge that uses the new limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| tlp_wr | input | 1 | A packet is written into the retry buffer this cycle |
| ack_rx | input | 1 | A valid Ack or Nak is received this cycle |
| rb_pend | input | 1 | Unacknowledged packets remain after this cycle's updates |
| link_speed | input | 2 | Negotiated speed code (0 = Gen1, 1 = Gen2) |
| link_width | input | 2 | Negotiated width code (0 = x1, 1 = x2, 2 = x4) |
| pol_we | input | 1 | Policy word write strobe |
| pol_wdata | input | 24 | Policy word write data |
| pol_rdata | output | 24 | Current policy word |
| timer_run | output | 1 | Timer is armed and counting |
| replay_req | output | 1 | One-cycle replay request |

## Verification
The assertions check the per-cycle control rules on every cycle:
- an acknowledgement restarts or stops the timer according to `rb_pend`;
- an idle timer arms only on a packet write;
- a replay request only occurs while the timer runs;
- policy writes land on the next edge and reset loads the default word.

Only the bench's scenarios can show the timing:
- the exact spacing of replay pulses for each speed/width selection and for the fallback codes;
- that a write during counting leaves the count alone;
- the zero-field and lowered-limit cases.

The bench shows this with a cycle-accurate reference model compared on every clock and with measured intervals.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = 6;
  localparam int POL_W      = FIELD_W * NUM_FIELDS;
  localparam int SLOT_W     = 3;

  localparam logic [POL_W-1:0] POL_DEFAULT = 24'hA64F96;

  // speed codes
  localparam logic [1:0] SPD_G1 = 2'd0;
  localparam logic [1:0] SPD_G2 = 2'd1;
  // width codes
  localparam logic [1:0] WID_X1 = 2'd0;
  localparam logic [1:0] WID_X2 = 2'd1;
  localparam logic [1:0] WID_X4 = 2'd2;

  // slot k occupies bits [4k+3:4k]
  localparam logic [SLOT_W-1:0] SLOT_G1X4 = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_G1X1 = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_G2X4 = 3'd3;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [1:0] spd,
                                                 input logic [1:0] wid);
    logic [SLOT_W-1:0] base;
    logic [SLOT_W-1:0] offs;
    logic              ok;
    ok   = 1'b1;
    base = SLOT_G1X4;
    offs = '0;
    case (spd)
      SPD_G1:  base = SLOT_G1X4;
      SPD_G2:  base = SLOT_G2X4;
      default: ok = 1'b0;
    endcase
    case (wid)
      WID_X4:  offs = 3'd0;
      WID_X2:  offs = 3'd1;
      WID_X1:  offs = 3'd2;
      default: ok = 1'b0;
    endcase
    return ok ? (base + offs) : SLOT_G1X1;
  endfunction

endpackage

// File: rtl/rtt_policy_reg.sv
module rtt_policy_reg #(
  parameter int              W       = 24,
  parameter logic [W-1:0]    DEFAULT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= DEFAULT;
    end else if (we) begin
      q <= wdata;
    end
  end

endmodule

// File: rtl/rtt_limit_sel.sv
module rtt_limit_sel
  import rtt_pkg::*;
#(
  parameter int SCALE = 64,
  parameter int LIM_W = 10
) (
  input  logic [POL_W-1:0] pol,
  input  logic [1:0]       spd,
  input  logic [1:0]       wid,
  output logic [LIM_W-1:0] limit
);

  logic [LIM_W-1:0]  lim_arr [NUM_FIELDS];
  logic [SLOT_W-1:0] slot;

  // one scaled limit per speed/width slot
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_slot
    assign lim_arr[i] = LIM_W'(pol[i*FIELD_W +: FIELD_W]) * LIM_W'(SCALE);
  end

  always_comb begin
    slot  = slot_of(spd, wid);
    limit = lim_arr[SLOT_G1X1];
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (slot == SLOT_W'(i)) limit = lim_arr[i];
    end
  end

endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int LIM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tlp_wr,
  input  logic             ack_rx,
  input  logic             rb_pend,
  input  logic [LIM_W-1:0] limit,
  output logic             run_q,
  output logic             rep_q
);

  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W:0]   cnt_inc;
  logic             expire;

  assign cnt_inc = {1'b0, cnt_q} + (LIM_W+1)'(1);
  // >= so that a lowered or zero limit expires at once
  assign expire  = cnt_inc >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      rep_q <= 1'b0;
    end else begin
      rep_q <= 1'b0;
      if (ack_rx) begin
        // acknowledgement wins over arm and expiry
        cnt_q <= '0;
        run_q <= rb_pend;
      end else if (!run_q) begin
        if (tlp_wr) begin
          cnt_q <= '0;
          run_q <= 1'b1;
        end
      end else if (expire) begin
        cnt_q <= '0;
        rep_q <= 1'b1;
      end else begin
        cnt_q <= cnt_inc[LIM_W-1:0];
      end
    end
  end

endmodule

// File: rtl/rtt_replay_timer.sv
module rtt_replay_timer
  import rtt_pkg::*;
#(
  parameter int SCALE = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tlp_wr,
  input  logic             ack_rx,
  input  logic             rb_pend,
  input  logic [1:0]       link_speed,
  input  logic [1:0]       link_width,
  input  logic             pol_we,
  input  logic [POL_W-1:0] pol_wdata,
  output logic [POL_W-1:0] pol_rdata,
  output logic             timer_run,
  output logic             replay_req
);

  localparam int MAX_LIM = ((1 << FIELD_W) - 1) * SCALE;
  localparam int LIM_W   = (MAX_LIM < 2) ? 1 : $clog2(MAX_LIM + 1);

  logic [LIM_W-1:0] limit;

  rtt_policy_reg #(
    .W       (POL_W),
    .DEFAULT (POL_DEFAULT)
  ) u_pol (
    .clk   (clk),
    .rst   (rst),
    .we    (pol_we),
    .wdata (pol_wdata),
    .q     (pol_rdata)
  );

  rtt_limit_sel #(
    .SCALE (SCALE),
    .LIM_W (LIM_W)
  ) u_sel (
    .pol   (pol_rdata),
    .spd   (link_speed),
    .wid   (link_width),
    .limit (limit)
  );

  rtt_counter #(
    .LIM_W (LIM_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tlp_wr  (tlp_wr),
    .ack_rx  (ack_rx),
    .rb_pend (rb_pend),
    .limit   (limit),
    .run_q   (timer_run),
    .rep_q   (replay_req)
  );

endmodule

// File: rtl/rtt_replay_timer_chk.sv
module rtt_replay_timer_chk
  import rtt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tlp_wr,
  input logic             ack_rx,
  input logic             rb_pend,
  input logic             pol_we,
  input logic [POL_W-1:0] pol_wdata,
  input logic [POL_W-1:0] pol_rdata,
  input logic             timer_run,
  input logic             replay_req
);

  a_r1_reset_default: assert property (@(posedge clk)
    rst |=> (pol_rdata == POL_DEFAULT) && !timer_run && !replay_req);

  a_r2_policy_load: assert property (@(posedge clk) disable iff (rst)
    pol_we |=> pol_rdata == $past(pol_wdata));

  a_r2_policy_hold: assert property (@(posedge clk) disable iff (rst)
    !pol_we |=> $stable(pol_rdata));

  a_r5_arm_on_write: assert property (@(posedge clk) disable iff (rst)
    (!timer_run && tlp_wr && !ack_rx) |=> timer_run && !replay_req);

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!timer_run && !tlp_wr && !ack_rx) |=> !timer_run && !replay_req);

  // R6 and R9: acknowledgement with packets left suppresses any replay
  a_r6_ack_restarts: assert property (@(posedge clk) disable iff (rst)
    (ack_rx && rb_pend) |=> timer_run && !replay_req);

  // R7 and R9: acknowledgement with buffer empty idles the timer
  a_r7_ack_empty_idles: assert property (@(posedge clk) disable iff (rst)
    (ack_rx && !rb_pend) |=> !timer_run && !replay_req);

  a_r8_replay_while_run: assert property (@(posedge clk) disable iff (rst)
    replay_req |-> timer_run);

endmodule

bind rtt_replay_timer rtt_replay_timer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tlp_wr     (tlp_wr),
  .ack_rx     (ack_rx),
  .rb_pend    (rb_pend),
  .pol_we     (pol_we),
  .pol_wdata  (pol_wdata),
  .pol_rdata  (pol_rdata),
  .timer_run  (timer_run),
  .replay_req (replay_req)
);

// File: tb/rtt_replay_timer_tb_top.sv
module rtt_replay_timer_tb_top;

  localparam int SCALE = 64;
  localparam logic [23:0] DEF_POL = 24'hA64F96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tlp_wr = 1'b0;
  logic        ack_rx = 1'b0;
  logic        rb_pend = 1'b0;
  logic [1:0]  link_speed = 2'd0;
  logic [1:0]  link_width = 2'd0;
  logic        pol_we = 1'b0;
  logic [23:0] pol_wdata = '0;
  logic [23:0] pol_rdata;
  logic        timer_run;
  logic        replay_req;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rtt_replay_timer #(.SCALE(SCALE)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .tlp_wr     (tlp_wr),
    .ack_rx     (ack_rx),
    .rb_pend    (rb_pend),
    .link_speed (link_speed),
    .link_width (link_width),
    .pol_we     (pol_we),
    .pol_wdata  (pol_wdata),
    .pol_rdata  (pol_rdata),
    .timer_run  (timer_run),
    .replay_req (replay_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_run = 0;
  bit          m_rep = 0;
  int          m_cnt = 0;
  logic [23:0] m_pol = DEF_POL;

  function automatic int model_limit(input logic [23:0] p,
                                     input logic [1:0] s, input logic [1:0] w);
    int fld;
    if (s > 2'd1 || w > 2'd2) fld = p[11:8];
    else if (s == 2'd0) fld = (w == 2'd0) ? p[11:8] : (w == 2'd1) ? p[7:4] : p[3:0];
    else fld = (w == 2'd0) ? p[23:20] : (w == 2'd1) ? p[19:16] : p[15:12];
    return fld * SCALE;
  endfunction

  always @(posedge clk) begin
    int lim;
    cycles <= cycles + 1;
    if (rst) begin
      m_run <= 0; m_rep <= 0; m_cnt <= 0; m_pol <= DEF_POL;
    end else begin
      lim = model_limit(m_pol, link_speed, link_width);
      m_rep <= 0;
      if (ack_rx) begin
        m_cnt <= 0; m_run <= rb_pend;
      end else if (!m_run) begin
        if (tlp_wr) begin m_run <= 1; m_cnt <= 0; end
      end else if (m_cnt + 1 >= lim) begin
        m_rep <= 1; m_cnt <= 0;
      end else begin
        m_cnt <= m_cnt + 1;
      end
      if (pol_we) m_pol <= pol_wdata;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 model replay_req", int'(replay_req), int'(m_rep));
      chk("R5 model timer_run", int'(timer_run), int'(m_run));
      chk("R2 model pol_rdata", int'(pol_rdata), int'(m_pol));
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm();
    tlp_wr = 1'b1; rb_pend = 1'b1;
    @(negedge clk);
    tlp_wr = 1'b0;
  endtask

  task automatic ack(input bit pend);
    ack_rx = 1'b1; rb_pend = pend;
    @(negedge clk);
    ack_rx = 1'b0;
  endtask

  task automatic wait_rep(output int k, input int maxc);
    k = 0;
    while (!replay_req && k < maxc) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic wr_pol(input logic [23:0] v);
    pol_we = 1'b1; pol_wdata = v;
    @(negedge clk);
    pol_we = 1'b0;
  endtask

  initial begin
    int k;
    int k2;
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pol default", int'(pol_rdata), int'(DEF_POL));
    chk("R1 timer idle", int'(timer_run), 0);
    chk("R1 no replay", int'(replay_req), 0);

    // R5 idle stays idle, R8 Gen1 x4 default = 6*64
    cyc(20);
    chk("R5 idle holds", int'(timer_run), 0);
    link_speed = 2'd0; link_width = 2'd2;
    arm();
    chk("R5 armed", int'(timer_run), 1);
    wait_rep(k, 2000);
    chk("R8 interval gen1 x4", k, 384);
    @(negedge clk);
    chk("R8 single-cycle pulse", int'(replay_req), 0);
    wait_rep(k, 2000);
    chk("R8 re-arm period", k + 1, 384);

    // R6 ack with pending restarts
    cyc(100);
    ack(1'b1);
    chk("R6 still running", int'(timer_run), 1);
    wait_rep(k, 2000);
    chk("R6 restart interval", k, 384);

    // R7 ack with empty buffer idles
    ack(1'b0);
    chk("R7 idle after ack", int'(timer_run), 0);
    wait_rep(k, 500);
    chk("R7 no replay while idle", k, 500);

    // R10 write while running does not restart
    arm();
    cyc(200);
    tlp_wr = 1'b1;
    @(negedge clk);
    tlp_wr = 1'b0;
    wait_rep(k2, 2000);
    chk("R10 no restart on write", 201 + k2, 384);
    ack(1'b0);

    // R9 ack on expiry cycle wins
    arm();
    cyc(383);
    ack(1'b0);
    chk("R9 no replay on ack cycle", int'(replay_req), 0);
    chk("R9 idle after ack", int'(timer_run), 0);

    // R2 / R3 policy write and Gen2 selection
    wr_pol(24'hA14F96);
    chk("R2 readback", int'(pol_rdata), int'(24'hA14F96));
    link_speed = 2'd1; link_width = 2'd1;
    arm();
    wait_rep(k, 2000);
    chk("R3 gen2 x2 = 1*64", k, 64);
    ack(1'b0);
    link_width = 2'd0;
    arm();
    wait_rep(k, 2000);
    chk("R3 gen2 x1 = 10*64", k, 640);
    ack(1'b0);

    // R4 fallback to Gen1 x1 field
    wr_pol(24'hA14296);
    link_speed = 2'd3; link_width = 2'd0;
    arm();
    wait_rep(k, 2000);
    chk("R4 bad speed fallback", k, 128);
    ack(1'b0);
    link_speed = 2'd0; link_width = 2'd3;
    arm();
    wait_rep(k, 2000);
    chk("R4 bad width fallback", k, 128);
    ack(1'b0);

    // R11 zero field replays every cycle
    wr_pol(24'hA14290);
    link_speed = 2'd0; link_width = 2'd2;
    arm();
    chk("R11 no replay on arm edge", int'(replay_req), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 replay every cycle", int'(replay_req), 1);
    end
    ack(1'b0);

    // R12 lowered limit fires on first edge that uses it
    wr_pol(24'hA14296);
    arm();
    cyc(200);
    wr_pol(24'hA14291);
    chk("R12 old limit still used", int'(replay_req), 0);
    @(negedge clk);
    chk("R12 replay after lowering", int'(replay_req), 1);

    // R1 reset while running
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset reloads default", int'(pol_rdata), int'(DEF_POL));
    chk("R1 reset stops timer", int'(timer_run), 0);
    cyc(5);
    finish_run();
  end

endmodule